// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Data Cache

This block is a direct-mapped data cache that sits between a load/store unit and a word-wide memory port. When a request arrives, the cache array is read with an index taken from the virtual address. At the same time, the virtual page number goes out on a translation port, and the physical frame number comes back in the same cycle. A hit means the selected line is valid and its stored frame number equals the translated one. The tag keeps the complete frame number, so the hit test does not depend on which virtual bits formed the index.

The cache can be larger than one 4 KB page. In that case the index reaches into translated virtual bits, and those bits form the access's color, which is reported with every response. Two virtual pages of different color that point at one physical frame occupy different lines, so duplicate copies can exist. Virtual pages of equal color share a line. Keeping aliases colored consistently is left to system software.

Loads that miss refill the whole line in word beats and then complete. Stores always write through to memory and update the cached word only on a hit. A flush input walks the index range and invalidates every line while holding off the CPU.

Top module: `vipt_dcache`

## Requirements
- R1: A load hits when the indexed line is valid and its stored frame number equals `xlat_pfn` in the acceptance cycle. The read word appears on `rsp_rdata` with `rsp_valid` in the cycle right after acceptance.
- R2: The line index is virtual address bits [OFF_W+IDX_W-1:OFF_W] (bits 12:4 by default, word select bits 3:2). `xlat_vpn` equals virtual bits [VA_W-1:12] in the same cycle as the request.
- R3: The tag stores the whole frame number. Two accesses with the same index whose frame numbers differ only in bit 0 do not hit on each other's line.
- R4: Each response carries `rsp_color`, equal to the accepted virtual address's index bits at position 12 and above (bit 12 by default).
- R5: Virtual pages of different color that map to one frame fill separate lines, and both then hit. Virtual pages of equal color share one line. A store through one color leaves the other color's copy unchanged.
- R6: A load miss issues exactly one read request at address {pfn, vaddr[11:4], 4'b0000}. It takes four 32-bit beats, with beat k holding the word at that address plus 4k. It then installs the line and responds with the requested word.
- R7: Every store issues one write request carrying the physical word address {pfn, vaddr[11:2], 2'b00} and the store data. On a hit it also updates the cached word.
- R8: A store miss allocates no line and issues no read request.
- R9: `flush` sampled high while idle invalidates every line. `req_ready` then stays low for exactly LINES cycles (512 by default), starting the cycle after the flush was sampled.
- R10: After reset `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and every line is invalid.
- R11: Once raised, `mem_req_valid` stays high with a stable address and direction until `mem_req_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Start invalidation of all lines |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | VA_W | Virtual byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Access completed |
| rsp_rdata | output | 32 | Load data |
| rsp_color | output | COLOR_PW | Color bits of the completed access |
| xlat_vpn | output | VA_W-12 | Virtual page number to translate |
| xlat_pfn | input | PA_W-12 | Frame number returned in the same cycle |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_we | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | PA_W | Physical byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rvalid | input | 1 | Refill beat present |
| mem_rdata | input | 32 | Refill beat data |

## Verification
The assertions assume that the translation port answers combinationally in the cycle the request is presented. They also assume that memory returns exactly four refill beats per read request, and only after accepting it. The bench's translation model is a pure function of `xlat_vpn`. Its memory model sends exactly four back-to-back beats two cycles after each accepted read and never sends beats unprompted. It toggles `mem_req_ready` every cycle so that requests are really held. Requests are word aligned and `flush` is raised only while the cache is idle between accesses.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_DATA = 3'd2,
        ST_FILL    = 3'd3,
        ST_WR      = 3'd4,
        ST_FLUSH   = 3'd5
    } vipt_state_e;
endpackage

// File: rtl/vipt_addr_split.sv
module vipt_addr_split #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int OFF_W     = 4,
    parameter int IDX_W     = 9,
    parameter int COLOR_W   = 1,
    parameter int COLOR_PW  = 1,
    localparam int WSEL_W   = OFF_W - 2,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic [VA_W-1:0]      vaddr,
    output logic [IDX_W-1:0]     idx,
    output logic [WSEL_W-1:0]    wsel,
    output logic [VPN_W-1:0]     vpn,
    output logic [PAGE_BITS-3:0] pword,
    output logic [COLOR_PW-1:0]  color
);
    logic unused_byte_bits;
    assign unused_byte_bits = &{1'b0, vaddr[1:0]};

    assign idx   = vaddr[OFF_W +: IDX_W];
    assign wsel  = vaddr[2 +: WSEL_W];
    assign vpn   = vaddr[VA_W-1:PAGE_BITS];
    assign pword = vaddr[PAGE_BITS-1:2];

    generate
        if (COLOR_W > 0) begin : g_color
            assign color = vaddr[PAGE_BITS +: COLOR_PW];
        end else begin : g_nocolor
            assign color = '0;
        end
    endgenerate
endmodule

// File: rtl/vipt_store.sv
module vipt_store #(
    parameter int LINES  = 512,
    parameter int IDX_W  = 9,
    parameter int PFN_W  = 20,
    parameter int BEATS  = 4,
    parameter int WSEL_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic                         rd_valid,
    output logic [PFN_W-1:0]             rd_tag,
    output logic [BEATS-1:0][31:0]       rd_line,
    input  logic                         fill_en,
    input  logic [IDX_W-1:0]             fill_idx,
    input  logic [PFN_W-1:0]             fill_tag,
    input  logic [BEATS-1:0][31:0]       fill_line,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [WSEL_W-1:0]            wr_wsel,
    input  logic [31:0]                  wr_data,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_idx
);
    logic [LINES-1:0]           valid_q, valid_d;
    logic [PFN_W-1:0]           tag_q  [LINES];
    logic [BEATS-1:0][31:0]     data_q [LINES];

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = data_q[rd_idx];

    always_comb begin
        valid_d = valid_q;
        if (fill_en) valid_d[fill_idx] = 1'b1;
        if (clr_en)  valid_d[clr_idx]  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_line;
        end
        if (wr_en) data_q[wr_idx][wr_wsel] <= wr_data;
    end

    assert_fill_clear_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && clr_en));
    assert_store_only_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> valid_q[wr_idx]);
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
#(
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int OFF_W     = 4,
    parameter int IDX_W     = 9,
    parameter int LINES     = 512,
    parameter int COLOR_PW  = 1,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int WSEL_W   = OFF_W - 2,
    localparam int BEATS    = 1 << WSEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [31:0]               req_wdata,
    output logic                      req_ready,
    input  logic [IDX_W-1:0]          in_idx,
    input  logic [WSEL_W-1:0]         in_wsel,
    input  logic [PAGE_BITS-3:0]      in_pword,
    input  logic [COLOR_PW-1:0]       in_color,
    input  logic [PFN_W-1:0]          xlat_pfn,
    input  logic                      rd_valid,
    input  logic [PFN_W-1:0]          rd_tag,
    input  logic [BEATS-1:0][31:0]    rd_line,
    output logic                      fill_en,
    output logic [IDX_W-1:0]          fill_idx,
    output logic [PFN_W-1:0]          fill_tag,
    output logic [BEATS-1:0][31:0]    fill_line,
    output logic                      wr_en,
    output logic                      clr_en,
    output logic [IDX_W-1:0]          clr_idx,
    output logic                      rsp_valid,
    output logic [31:0]               rsp_rdata,
    output logic [COLOR_PW-1:0]       rsp_color,
    output logic                      mem_req_valid,
    output logic                      mem_req_we,
    output logic [PA_W-1:0]           mem_req_addr,
    output logic [31:0]               mem_req_wdata,
    input  logic                      mem_req_ready,
    input  logic                      mem_rvalid,
    input  logic [31:0]               mem_rdata
);
    typedef struct packed {
        vipt_state_e              st;
        logic [IDX_W-1:0]         idx;
        logic [WSEL_W-1:0]        wsel;
        logic [PFN_W-1:0]         pfn;
        logic [PAGE_BITS-3:0]     pword;
        logic [31:0]              wdata;
        logic [WSEL_W-1:0]        beat;
        logic [BEATS-1:0][31:0]   linebuf;
        logic [COLOR_PW-1:0]      color;
        logic                     rsp_v;
        logic [31:0]              rsp_d;
        logic [COLOR_PW-1:0]      rsp_c;
        logic [IDX_W-1:0]         fcnt;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;
    logic  hit, accept;

    assign req_ready = (ctl_q.st == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign hit       = rd_valid && (rd_tag == xlat_pfn);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rsp_v   = 1'b0;
        wr_en         = 1'b0;
        clr_en        = 1'b0;
        fill_en       = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = {ctl_q.pfn, ctl_q.pword[PAGE_BITS-3:WSEL_W], {OFF_W{1'b0}}};
        case (ctl_q.st)
            ST_IDLE: begin
                if (flush) begin
                    ctl_d.st   = ST_FLUSH;
                    ctl_d.fcnt = '0;
                end else if (req_valid) begin
                    ctl_d.idx   = in_idx;
                    ctl_d.wsel  = in_wsel;
                    ctl_d.pfn   = xlat_pfn;
                    ctl_d.pword = in_pword;
                    ctl_d.wdata = req_wdata;
                    ctl_d.color = in_color;
                    if (req_write) begin
                        wr_en    = hit;
                        ctl_d.st = ST_WR;
                    end else if (hit) begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.rsp_d = rd_line[in_wsel];
                        ctl_d.rsp_c = in_color;
                    end else begin
                        ctl_d.st   = ST_RD_REQ;
                        ctl_d.beat = '0;
                    end
                end
            end
            ST_RD_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) ctl_d.st = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (mem_rvalid) begin
                    ctl_d.linebuf[ctl_q.beat] = mem_rdata;
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == WSEL_W'(BEATS - 1)) ctl_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                fill_en     = 1'b1;
                ctl_d.rsp_v = 1'b1;
                ctl_d.rsp_d = ctl_q.linebuf[ctl_q.wsel];
                ctl_d.rsp_c = ctl_q.color;
                ctl_d.st    = ST_IDLE;
            end
            ST_WR: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = {ctl_q.pfn, ctl_q.pword, 2'b00};
                if (mem_req_ready) begin
                    ctl_d.rsp_v = 1'b1;
                    ctl_d.rsp_d = '0;
                    ctl_d.rsp_c = ctl_q.color;
                    ctl_d.st    = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                clr_en     = 1'b1;
                ctl_d.fcnt = ctl_q.fcnt + 1'b1;
                if (ctl_q.fcnt == IDX_W'(LINES - 1)) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fill_idx      = ctl_q.idx;
    assign fill_tag      = ctl_q.pfn;
    assign fill_line     = ctl_q.linebuf;
    assign clr_idx       = ctl_q.fcnt;
    assign mem_req_wdata = ctl_q.wdata;
    assign rsp_valid     = ctl_q.rsp_v;
    assign rsp_rdata     = ctl_q.rsp_d;
    assign rsp_color     = ctl_q.rsp_c;

    assert_hit_next_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && hit) |=> rsp_valid);
    assert_read_line_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> (mem_req_addr[OFF_W-1:0] == '0));
    assert_store_no_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |=> (mem_req_valid && mem_req_we));
    assert_flush_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && flush) |=> !req_ready);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
    import vipt_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int PAGE_BITS   = 12,
    parameter int CACHE_BYTES = 8192,
    parameter int LINE_BYTES  = 16,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int LINES      = CACHE_BYTES / LINE_BYTES,
    localparam int IDX_W      = $clog2(LINES),
    localparam int COLOR_W    = OFF_W + IDX_W - PAGE_BITS,
    localparam int COLOR_PW   = (COLOR_W > 0) ? COLOR_W : 1,
    localparam int PFN_W      = PA_W - PAGE_BITS,
    localparam int VPN_W      = VA_W - PAGE_BITS,
    localparam int WSEL_W     = OFF_W - 2,
    localparam int BEATS      = 1 << WSEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic [COLOR_PW-1:0]  rsp_color,
    output logic [VPN_W-1:0]     xlat_vpn,
    input  logic [PFN_W-1:0]     xlat_pfn,
    output logic                 mem_req_valid,
    output logic                 mem_req_we,
    output logic [PA_W-1:0]      mem_req_addr,
    output logic [WORD_W-1:0]    mem_req_wdata,
    input  logic                 mem_req_ready,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata
);
    logic [IDX_W-1:0]          a_idx;
    logic [WSEL_W-1:0]         a_wsel;
    logic [PAGE_BITS-3:0]      a_pword;
    logic [COLOR_PW-1:0]       a_color;
    logic                      s_valid;
    logic [PFN_W-1:0]          s_tag;
    logic [BEATS-1:0][31:0]    s_line;
    logic                      f_en, w_en, c_en;
    logic [IDX_W-1:0]          f_idx, c_idx;
    logic [PFN_W-1:0]          f_tag;
    logic [BEATS-1:0][31:0]    f_line;

    vipt_addr_split #(
        .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .COLOR_W(COLOR_W), .COLOR_PW(COLOR_PW)
    ) split_i (
        .vaddr(req_vaddr), .idx(a_idx), .wsel(a_wsel), .vpn(xlat_vpn),
        .pword(a_pword), .color(a_color)
    );

    vipt_store #(
        .LINES(LINES), .IDX_W(IDX_W), .PFN_W(PFN_W), .BEATS(BEATS), .WSEL_W(WSEL_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(a_idx), .rd_valid(s_valid), .rd_tag(s_tag), .rd_line(s_line),
        .fill_en(f_en), .fill_idx(f_idx), .fill_tag(f_tag), .fill_line(f_line),
        .wr_en(w_en), .wr_idx(a_idx), .wr_wsel(a_wsel), .wr_data(req_wdata),
        .clr_en(c_en), .clr_idx(c_idx)
    );

    vipt_ctrl #(
        .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .LINES(LINES), .COLOR_PW(COLOR_PW)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready),
        .in_idx(a_idx), .in_wsel(a_wsel), .in_pword(a_pword), .in_color(a_color),
        .xlat_pfn(xlat_pfn),
        .rd_valid(s_valid), .rd_tag(s_tag), .rd_line(s_line),
        .fill_en(f_en), .fill_idx(f_idx), .fill_tag(f_tag), .fill_line(f_line),
        .wr_en(w_en), .clr_en(c_en), .clr_idx(c_idx),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_color(rsp_color),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );
endmodule

// File: tb/vipt_dcache_tb_top.sv
`timescale 1ns/100ps
module vipt_dcache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [0:0]  rsp_color;
    logic [19:0] xlat_vpn;
    logic [19:0] xlat_pfn;
    logic        mem_req_valid, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_req_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    vipt_dcache dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_color(rsp_color),
        .xlat_vpn(xlat_vpn), .xlat_pfn(xlat_pfn),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [19:0] xlate(input logic [19:0] vpn);
        case (vpn)
            20'h1, 20'h2, 20'h3: xlate = 20'hF;
            20'h40:              xlate = 20'h200;
            20'h42:              xlate = 20'h201;
            default:             xlate = vpn + 20'h100;
        endcase
    endfunction
    always_comb xlat_pfn = xlate(xlat_vpn);

    logic [31:0] wmem [logic [31:0]];
    function automatic logic [31:0] init_word(input logic [31:0] pa);
        return pa ^ 32'h3C3C_0000;
    endfunction
    function automatic logic [31:0] mem_word(input logic [31:0] pa);
        if (wmem.exists(pa)) return wmem[pa];
        return init_word(pa);
    endfunction

    int          rd_count = 0, wr_count = 0;
    logic [31:0] last_raddr = '0, last_waddr = '0, last_wdata = '0;
    logic [31:0] beat_base = '0;
    int          beats_left = 0, beat_delay = 0;

    always @(posedge clk) begin
        mem_req_ready <= rst_n ? ~mem_req_ready : 1'b0;
        mem_rvalid    <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                wmem[mem_req_addr] = mem_req_wdata;
                wr_count   <= wr_count + 1;
                last_waddr <= mem_req_addr;
                last_wdata <= mem_req_wdata;
            end else begin
                rd_count   <= rd_count + 1;
                last_raddr <= mem_req_addr;
                beat_base  <= mem_req_addr;
                beats_left <= 4;
                beat_delay <= 2;
            end
        end else if (beats_left > 0) begin
            if (beat_delay > 0) beat_delay <= beat_delay - 1;
            else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_word(beat_base + 32'(4 * (4 - beats_left)));
                beats_left <= beats_left - 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] va, input logic [31:0] wd,
                          output logic [31:0] rd, output logic [0:0] col, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_vaddr = va; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        check(xlat_vpn == va[31:12], "R2 vpn", 32'(xlat_vpn), 32'(va[31:12]));
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        rd  = rsp_rdata;
        col = rsp_color;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] va;
        logic [31:0] wd;
        logic        chk_hit;
        logic        exp_hit;
        logic        stale;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_5000, 32'h0,          1'b1, 1'b0, 1'b0},
        '{1'b0, 32'h0000_5004, 32'h0,          1'b1, 1'b1, 1'b0},
        '{1'b0, 32'h0000_500C, 32'h0,          1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h0000_5008, 32'h1111_2222,  1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h0000_5008, 32'h0,          1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h0000_6010, 32'hCAFE_F00D,  1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h0000_6010, 32'h0,          1'b1, 1'b0, 1'b0},
        '{1'b0, 32'h0000_1000, 32'h0,          1'b1, 1'b0, 1'b0},
        '{1'b0, 32'h0000_2004, 32'h0,          1'b1, 1'b0, 1'b0},
        '{1'b0, 32'h0000_1004, 32'h0,          1'b1, 1'b1, 1'b0},
        '{1'b0, 32'h0000_2008, 32'h0,          1'b1, 1'b1, 1'b0},
        '{1'b0, 32'h0000_300C, 32'h0,          1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h0000_2000, 32'hABCD_0123,  1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h0000_2000, 32'h0,          1'b1, 1'b1, 1'b0},
        '{1'b0, 32'h0000_1000, 32'h0,          1'b1, 1'b1, 1'b1},
        '{1'b0, 32'h0004_0000, 32'h0,          1'b1, 1'b0, 1'b0},
        '{1'b0, 32'h0004_2000, 32'h0,          1'b1, 1'b0, 1'b0},
        '{1'b0, 32'h0004_0000, 32'h0,          1'b1, 1'b0, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] rd, pa, exp;
        logic [0:0]  col;
        int          lat, rc0, wc0, n;

        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready", 32'(req_ready), 32'h1);
        check(rsp_valid == 1'b0, "R10 rsp_valid", 32'(rsp_valid), 32'h0);
        check(mem_req_valid == 1'b0, "R10 mem_req_valid", 32'(mem_req_valid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            rc0 = rd_count;
            wc0 = wr_count;
            pa  = {xlate(VECS[i].va[31:12]), VECS[i].va[11:0]};
            access(VECS[i].we, VECS[i].va, VECS[i].wd, rd, col, lat);
            check(rsp_valid, "R1 completion", 32'(rsp_valid), 32'h1);
            check(col == VECS[i].va[12], "R4 color", 32'(col), 32'(VECS[i].va[12]));
            if (VECS[i].we) begin
                check(wr_count == wc0 + 1 && last_waddr == pa && last_wdata == VECS[i].wd,
                      "R7 write-through", last_waddr, pa);
                check(rd_count == rc0, "R8 no refill on store", 32'(rd_count), 32'(rc0));
            end else begin
                exp = VECS[i].stale ? init_word(pa) : mem_word(pa);
                check(rd == exp, VECS[i].stale ? "R5 stale alias copy" : "R1/R6 load data",
                      rd, exp);
                if (VECS[i].chk_hit) begin
                    check((lat == 1) == VECS[i].exp_hit, "R1/R3/R5 hit or miss",
                          32'(lat), VECS[i].exp_hit ? 32'd1 : 32'd2);
                end
                if (!VECS[i].exp_hit) begin
                    check(rd_count == rc0 + 1 && last_raddr == {pa[31:4], 4'h0},
                          "R6 refill address", last_raddr, {pa[31:4], 4'h0});
                end
            end
        end

        access(1'b0, 32'h0004_0000, 32'h0, rd, col, lat);
        check(lat == 1, "R1 hit before flush", 32'(lat), 32'd1);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        n = 0;
        while (!req_ready && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check(n == 512, "R9 flush stall cycles", 32'(n), 32'd512);
        rc0 = rd_count;
        access(1'b0, 32'h0004_0000, 32'h0, rd, col, lat);
        check(lat > 1 && rd_count == rc0 + 1, "R9 line invalid after flush", 32'(lat), 32'd2);
        check(rd == init_word(32'h0020_0000), "R9 data after flush", rd,
              init_word(32'h0020_0000));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule